// File: doc/BRIEF.md
# Bus-to-Packet Bridge

This block connects a processor core's simple request/reply bus to a byte-serial, layered packet link. The core offers a request that carries a command, an address and up to four bytes of write data. The bridge picks the target node from the address and wraps the request in a packet with three layers. The transaction layer holds an operation code, the address and the data. The routing layer holds the source and destination node numbers. The link layer holds a sequence tag, kept separately for each destination, and a check byte. The link consumes one transmit credit per packet, and a pulse on a grant input adds a fixed batch of credits.

Only one request is in flight at a time. After a request is launched, the bridge waits for a completion packet that matches the request. A matching completion becomes a Done reply on the bus, with any returned read bytes. A returning packet that fails any header, tag or length test raises a one-cycle error pulse and is dropped. The request stays pending until a good completion arrives.

Top module: `pkt_bridge`

## Requirements
- R1: `req_cmd` 0 means read and 1 means write. Every reply has `rsp_cmd` = 2 (Done). A request with code 2 or 3 is answered with Done, `rsp_len` 0 and `rsp_data` 0, and no packet is sent.
- R2: If the request address MSB is 0, the target is the memory node (parameter `MEM_NODE`, default 0). If it is 1, the target is the device node given by the low `NODE_W` address bits.
- R3: An outgoing packet is sent as these bytes, in this order: code; route byte (source = `SELF_NODE` in bits 7:4, destination in bits 3:0); tag; address bytes, most significant first; data bytes, `req_data[7:0]` first; check byte. `tx_sop` marks the first byte and `tx_eop` marks the last.
- R4: The operation codes are 0x10 for memory read, 0x11 for memory write, 0x20 for device read and 0x21 for device write.
- R5: Each destination node has its own tag. A tag starts at 0 after reset, goes up by one with each packet launched to that node, and wraps from 3 back to 0.
- R6: The check byte equals the number of data bytes in the packet. Reads carry no data. Write length is `req_len`, clamped to 4.
- R7: `req_ready` is high only when the bridge is idle. It drops after a request is accepted and returns only after the reply has been taken with `rsp_ready`. No packet is transmitted while a reply is pending.
- R8: There are no credits after reset. Each `credit_grant` pulse adds 4. A packet can start only while the credit count is nonzero, and each packet uses one credit. Without credit, a request waits with `tx_valid` low.
- R9: A completion is accepted when all of these hold: code 0x50; route source equals the request's target; route destination equals `SELF_NODE`; tag equals the request's tag; at most 4 data bytes; check byte equals the data byte count. On acceptance the reply returns the data, first byte in `rsp_data[7:0]`, unused lanes 0, with `rsp_len` equal to the count.
- R10: An incoming packet that fails any test in R9, or that ends before its tag byte, makes `pkt_err` high for exactly one cycle. The packet is dropped and the request stays pending.
- R11: A completion that arrives while no request is waiting raises `pkt_err` and produces no reply.
- R12: While `tx_valid` is high and `tx_ready` is low, the outgoing byte and its markers hold. While `rsp_valid` is high and `rsp_ready` is low, the reply fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Bridge idle, can take a request |
| req_cmd | input | 2 | Request command (0 read, 1 write) |
| req_addr | input | ADDR_W | Request address; MSB selects device space |
| req_data | input | 8*DATA_BYTES | Write data, byte 0 in low lane |
| req_len | input | LEN_W | Write byte count |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Core takes the reply |
| rsp_cmd | output | 2 | Reply command, always Done (2) |
| rsp_data | output | 8*DATA_BYTES | Returned read bytes |
| rsp_len | output | LEN_W | Number of returned bytes |
| credit_grant | input | 1 | Adds one batch of transmit credits |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_sop | input | 1 | First byte of incoming packet |
| rx_eop | input | 1 | Last byte of incoming packet |
| pkt_err | output | 1 | One-cycle pulse for a dropped packet |

## Verification
If a tag counter is corrupted or not steered correctly, the next packet to the affected node carries a wrong tag byte at position 2. A completion echoing the expected tag is then rejected with an error pulse, one cycle after its last byte. A fault in the credit count shows up in either of two ways: a packet leaves before any grant, or a request stays stuck with `tx_valid` low after a grant. Because the bench counts credits itself, both are caught on the first affected request. A wrong pending-request state appears at the handshake ports: `req_ready` rises before the reply is taken, or an idle completion produces a reply.

// File: rtl/pkt_bridge_pkg.sv
package pkt_bridge_pkg;
  localparam logic [7:0] OP_MEM_RD = 8'h10;
  localparam logic [7:0] OP_MEM_WR = 8'h11;
  localparam logic [7:0] OP_DEV_RD = 8'h20;
  localparam logic [7:0] OP_DEV_WR = 8'h21;
  localparam logic [7:0] OP_CPL    = 8'h50;

  localparam logic [1:0] BUS_RD   = 2'd0;
  localparam logic [1:0] BUS_WR   = 2'd1;
  localparam logic [1:0] BUS_DONE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_XMIT,
    ST_WAIT,
    ST_RESP
  } br_state_t;
endpackage

// File: rtl/pb_credit.sv
module pb_credit #(
  parameter int CREDIT_N   = 4,
  parameter int CREDIT_MAX = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic take,
  output logic avail
);
  localparam int CW = $clog2(CREDIT_MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW:0]   sum;

  always_comb begin
    sum = {1'b0, cnt};
    if (grant) sum = sum + (CW+1)'(CREDIT_N);
    if (take)  sum = sum - (CW+1)'(1);
    if (sum > (CW+1)'(CREDIT_MAX)) sum = (CW+1)'(CREDIT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= sum[CW-1:0];
  end

  assign avail = (cnt != '0);

  AST_TAKE_HAS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    take |-> cnt != '0); // R8
endmodule

// File: rtl/pb_tag_table.sv
module pb_tag_table #(
  parameter int NODE_W = 2,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] sel,
  input  logic              bump,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int NODES = 1 << NODE_W;

  logic [TAG_W-1:0] tags [NODES];

  for (genvar i = 0; i < NODES; i++) begin : g_node
    always_ff @(posedge clk) begin
      if (rst)                              tags[i] <= '0;
      else if (bump && sel == NODE_W'(i))   tags[i] <= tags[i] + TAG_W'(1);
    end

    AST_TAG_QUIET: assert property (@(posedge clk) disable iff (rst)
      !(bump && sel == NODE_W'(i)) |=> $stable(tags[i])); // R5
  end

  assign tag_o = tags[sel];
endmodule

// File: rtl/pb_tx.sv
module pb_tx #(
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 4,
  parameter int TAG_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [7:0]              code,
  input  logic [7:0]              route,
  input  logic [TAG_W-1:0]        tag,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [8*DATA_BYTES-1:0] data,
  input  logic [$clog2(DATA_BYTES+1)-1:0] len,
  output logic                    done,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [7:0]              tx_data,
  output logic                    tx_sop,
  output logic                    tx_eop
);
  localparam int AB    = ADDR_W / 8;
  localparam int HDR   = 3 + AB;
  localparam int LEN_W = $clog2(DATA_BYTES + 1);
  localparam int IW    = $clog2(HDR + DATA_BYTES + 1) + 1;

  logic                    busy;
  logic [IW-1:0]           idx;
  logic [7:0]              r_code, r_route;
  logic [TAG_W-1:0]        r_tag;
  logic [ADDR_W-1:0]       r_addr, a_sh;
  logic [8*DATA_BYTES-1:0] r_data, d_sh;
  logic [LEN_W-1:0]        r_len;
  logic [IW-1:0]           last_idx;
  logic [7:0]              byte_q;

  assign last_idx = IW'(HDR) + IW'(r_len);

  always_comb begin
    byte_q = 8'h00;
    a_sh   = '0;
    d_sh   = '0;
    if (idx == IW'(0))        byte_q = r_code;
    else if (idx == IW'(1))   byte_q = r_route;
    else if (idx == IW'(2))   byte_q = 8'(r_tag);
    else if (idx < IW'(HDR)) begin
      a_sh   = r_addr >> (8 * (HDR - 1 - int'(idx)));
      byte_q = a_sh[7:0];
    end else if (idx < last_idx) begin
      d_sh   = r_data >> (8 * (int'(idx) - HDR));
      byte_q = d_sh[7:0];
    end else begin
      byte_q = 8'(r_len);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      r_code  <= '0;
      r_route <= '0;
      r_tag   <= '0;
      r_addr  <= '0;
      r_data  <= '0;
      r_len   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        idx     <= '0;
        r_code  <= code;
        r_route <= route;
        r_tag   <= tag;
        r_addr  <= addr;
        r_data  <= data;
        r_len   <= len;
      end else if (busy && tx_ready) begin
        if (idx == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  assign tx_valid = busy;
  assign tx_data  = byte_q;
  assign tx_sop   = busy && (idx == IW'(0));
  assign tx_eop   = busy && (idx == last_idx);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eop)); // R12
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R7
endmodule

// File: rtl/pb_rx.sv
module pb_rx
  import pkt_bridge_pkg::*;
#(
  parameter int NODE_W     = 2,
  parameter int TAG_W      = 2,
  parameter int DATA_BYTES = 4,
  parameter int SELF_NODE  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_sop,
  input  logic                    rx_eop,
  input  logic                    waiting,
  input  logic [NODE_W-1:0]       exp_src,
  input  logic [TAG_W-1:0]        exp_tag,
  output logic                    ok,
  output logic                    err,
  output logic [8*DATA_BYTES-1:0] buf_o,
  output logic [$clog2(DATA_BYTES+1)-1:0] len_o
);
  localparam int LEN_W = $clog2(DATA_BYTES + 1);

  logic             in_pkt;
  logic [1:0]       pos;
  logic             code_bad, route_bad, tag_bad, over;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       exp_route;
  logic             good;

  assign exp_route = {4'(exp_src), 4'(SELF_NODE)};
  assign good = waiting && !code_bad && !route_bad && !tag_bad && !over
                && (rx_data == 8'(cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      pos       <= '0;
      code_bad  <= 1'b0;
      route_bad <= 1'b0;
      tag_bad   <= 1'b0;
      over      <= 1'b0;
      cnt       <= '0;
      ok        <= 1'b0;
      err       <= 1'b0;
      buf_o     <= '0;
      len_o     <= '0;
    end else begin
      ok  <= 1'b0;
      err <= 1'b0;
      if (rx_valid) begin
        if (rx_sop) begin
          in_pkt   <= !rx_eop;
          pos      <= 2'd1;
          code_bad <= (rx_data != OP_CPL);
          over     <= 1'b0;
          cnt      <= '0;
          buf_o    <= '0;
          if (rx_eop) err <= 1'b1;
        end else if (in_pkt) begin
          case (pos)
            2'd1: begin
              route_bad <= (rx_data != exp_route);
              pos       <= 2'd2;
              if (rx_eop) begin
                in_pkt <= 1'b0;
                err    <= 1'b1;
              end
            end
            2'd2: begin
              tag_bad <= (rx_data != 8'(exp_tag));
              pos     <= 2'd3;
              if (rx_eop) begin
                in_pkt <= 1'b0;
                err    <= 1'b1;
              end
            end
            default: begin
              if (rx_eop) begin
                in_pkt <= 1'b0;
                ok     <= good;
                err    <= !good;
                len_o  <= cnt;
              end else if (cnt < LEN_W'(DATA_BYTES)) begin
                buf_o[8*int'(cnt) +: 8] <= rx_data;
                cnt <= cnt + LEN_W'(1);
              end else begin
                over <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  AST_OK_XOR_ERR: assert property (@(posedge clk) disable iff (rst)
    ok |-> !err); // R10
  AST_OK_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    ok |-> $past(waiting)); // R11
endmodule

// File: rtl/pkt_bridge.sv
module pkt_bridge
  import pkt_bridge_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 4,
  parameter int NODE_W     = 2,
  parameter int TAG_W      = 2,
  parameter int SELF_NODE  = 1,
  parameter int MEM_NODE   = 0,
  parameter int CREDIT_N   = 4,
  parameter int CREDIT_MAX = 15,
  localparam int LEN_W     = $clog2(DATA_BYTES + 1),
  localparam int DW        = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_cmd,
  output logic [DW-1:0]     rsp_data,
  output logic [LEN_W-1:0]  rsp_len,
  input  logic              credit_grant,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  output logic              pkt_err
);
  br_state_t         state;
  logic [NODE_W-1:0] cur_dst, req_dst;
  logic [7:0]        cur_code, req_code;
  logic [ADDR_W-1:0] cur_addr;
  logic [DW-1:0]     cur_data;
  logic [LEN_W-1:0]  cur_len, wr_len;
  logic [TAG_W-1:0]  cur_tag, tbl_tag;
  logic              accept, send_go, credit_ok, tx_done;
  logic              rx_ok, rx_err;
  logic [DW-1:0]     rx_buf;
  logic [LEN_W-1:0]  rx_len;
  logic [7:0]        route_b;

  assign accept  = req_valid && req_ready;
  assign req_dst = req_addr[ADDR_W-1] ? req_addr[NODE_W-1:0] : NODE_W'(MEM_NODE);
  assign req_code = req_addr[ADDR_W-1] ? ((req_cmd == BUS_WR) ? OP_DEV_WR : OP_DEV_RD)
                                       : ((req_cmd == BUS_WR) ? OP_MEM_WR : OP_MEM_RD);
  assign wr_len  = (req_len > LEN_W'(DATA_BYTES)) ? LEN_W'(DATA_BYTES) : req_len;
  assign send_go = (state == ST_SEND) && credit_ok;
  assign route_b = {4'(SELF_NODE), 4'(cur_dst)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_dst  <= '0;
      cur_code <= '0;
      cur_addr <= '0;
      cur_data <= '0;
      cur_len  <= '0;
      cur_tag  <= '0;
      rsp_data <= '0;
      rsp_len  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (req_cmd == BUS_RD || req_cmd == BUS_WR) begin
            cur_dst  <= req_dst;
            cur_code <= req_code;
            cur_addr <= req_addr;
            cur_data <= (req_cmd == BUS_WR) ? req_data : '0;
            cur_len  <= (req_cmd == BUS_WR) ? wr_len : '0;
            state    <= ST_SEND;
          end else begin
            rsp_data <= '0;
            rsp_len  <= '0;
            state    <= ST_RESP;
          end
        end
        ST_SEND: if (send_go) begin
          cur_tag <= tbl_tag;
          state   <= ST_XMIT;
        end
        ST_XMIT: if (tx_done) state <= ST_WAIT;
        ST_WAIT: if (rx_ok) begin
          rsp_data <= rx_buf;
          rsp_len  <= rx_len;
          state    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_cmd   = BUS_DONE;
  assign pkt_err   = rx_err;

  pb_credit #(.CREDIT_N(CREDIT_N), .CREDIT_MAX(CREDIT_MAX)) u_credit (
    .clk(clk), .rst(rst), .grant(credit_grant), .take(send_go), .avail(credit_ok)
  );

  pb_tag_table #(.NODE_W(NODE_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .sel(cur_dst), .bump(send_go), .tag_o(tbl_tag)
  );

  pb_tx #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .TAG_W(TAG_W)) u_tx (
    .clk(clk), .rst(rst), .start(send_go), .code(cur_code), .route(route_b),
    .tag(tbl_tag), .addr(cur_addr), .data(cur_data), .len(cur_len), .done(tx_done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  pb_rx #(.NODE_W(NODE_W), .TAG_W(TAG_W), .DATA_BYTES(DATA_BYTES),
          .SELF_NODE(SELF_NODE)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .waiting(state == ST_WAIT), .exp_src(cur_dst), .exp_tag(cur_tag),
    .ok(rx_ok), .err(rx_err), .buf_o(rx_buf), .len_o(rx_len)
  );

  AST_REPLY_BLOCKS_TX: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !tx_valid); // R7
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_len)); // R12
endmodule

// File: tb/pkt_bridge_test.sv
module pkt_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_cmd = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [2:0]  req_len = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [1:0]  rsp_cmd;
  logic [31:0] rsp_data;
  logic [2:0]  rsp_len;
  logic        credit_grant = 1'b0;
  logic        tx_valid, tx_ready = 1'b0, tx_sop, tx_eop;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        pkt_err;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] got [16];
  logic [7:0] exp_b [16];
  int got_n, exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_bridge uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cmd(rsp_cmd),
    .rsp_data(rsp_data), .rsp_len(rsp_len), .credit_grant(credit_grant),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .pkt_err(pkt_err)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic grant();
    credit_grant = 1'b1;
    @(negedge clk);
    credit_grant = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c, input logic [15:0] a,
                       input logic [31:0] d, input logic [2:0] l);
    req_cmd = c; req_addr = a; req_data = d; req_len = l; req_valid = 1'b1;
    for (int i = 0; i < 50; i++) begin
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Expected request packet, built from R3, R4, R6
  task automatic mk_exp(input logic [7:0] code, input logic [7:0] route,
                        input logic [7:0] tag, input logic [15:0] a,
                        input logic [31:0] d, input int n);
    exp_b[0] = code; exp_b[1] = route; exp_b[2] = tag;
    exp_b[3] = a[15:8]; exp_b[4] = a[7:0];
    for (int i = 0; i < n; i++) exp_b[5+i] = d[8*i +: 8];
    exp_b[5+n] = 8'(n);
    exp_n = 6 + n;
  endtask

  task automatic get_pkt(input string rq);
    got_n = 0;
    tx_ready = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (tx_valid) begin
        if (got_n == 0) chk({rq, " sop on first byte (R3)"}, 32'(tx_sop), 32'd1);
        got[got_n] = tx_data;
        got_n++;
        if (tx_eop || got_n == 16) begin
          @(negedge clk);
          break;
        end
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk({rq, " packet length"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk($sformatf("%s byte %0d", rq, i), 32'(got[i]), 32'(exp_b[i]));
  endtask

  task automatic send_cpl(input string rq, input logic [7:0] code, input logic [7:0] route,
                          input logic [7:0] tag, input logic [39:0] d, input int n,
                          input logic [7:0] ck, input logic want_err);
    int total;
    total = 4 + n;
    for (int i = 0; i < total; i++) begin
      rx_valid = 1'b1;
      rx_sop = (i == 0);
      rx_eop = (i == total - 1);
      if (i == 0)              rx_data = code;
      else if (i == 1)         rx_data = route;
      else if (i == 2)         rx_data = tag;
      else if (i < total - 1)  rx_data = d[8*(i-3) +: 8];
      else                     rx_data = ck;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    chk({rq, " pkt_err pulse"}, 32'(pkt_err), 32'(want_err));
    @(negedge clk);
    chk({rq, " pkt_err one cycle (R10)"}, 32'(pkt_err), 32'd0);
  endtask

  task automatic wait_rsp(input string rq, input logic [31:0] d, input logic [2:0] l);
    int seen;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    chk({rq, " reply valid"}, 32'(seen), 32'd1);
    chk({rq, " rsp_cmd Done R1"}, 32'(rsp_cmd), 32'd2);
    chk({rq, " rsp_data R9"}, rsp_data, d);
    chk({rq, " rsp_len R9"}, 32'(rsp_len), 32'(l));
    chk({rq, " req_ready low while pending R7"}, 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk({rq, " reply held R12"}, {rsp_data[30:0], rsp_valid}, {d[30:0], 1'b1});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({rq, " reply dropped"}, 32'(rsp_valid), 32'd0);
    chk({rq, " ready again R7"}, 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R7 reset req_ready", 32'(req_ready), 32'd1);
    chk("R8 reset tx_valid", 32'(tx_valid), 32'd0);
    chk("R7 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset pkt_err", 32'(pkt_err), 32'd0);
  endtask

  task automatic t_credit_and_mem_write();
    issue(2'd1, 16'h0004, 32'h00CCBBAA, 3'd3);
    for (int i = 0; i < 12; i++) begin
      chk("R8 no credit no packet", 32'(tx_valid), 32'd0);
      @(negedge clk);
    end
    chk("R7 busy during stall", 32'(req_ready), 32'd0);
    grant();
    mk_exp(8'h11, 8'h10, 8'h00, 16'h0004, 32'h00CCBBAA, 3);
    get_pkt("R3 R4 R6 mem write");
    send_cpl("R9 mem write cpl", 8'h50, 8'h01, 8'h00, 40'h0, 0, 8'h00, 1'b0);
    wait_rsp("R9 mem write", 32'h0, 3'd0);
  endtask

  task automatic t_illegal_cmd();
    int saw_tx;
    saw_tx = 0;
    issue(2'd2, 16'h0008, 32'h12345678, 3'd2);
    for (int i = 0; i < 4; i++) begin
      if (tx_valid) saw_tx = 1;
      @(negedge clk);
    end
    chk("R1 illegal code sends no packet", 32'(saw_tx), 32'd0);
    wait_rsp("R1 illegal code", 32'h0, 3'd0);
  endtask

  task automatic t_dev_read();
    issue(2'd0, 16'h8002, 32'hFFFFFFFF, 3'd4);
    mk_exp(8'h20, 8'h12, 8'h00, 16'h8002, 32'h0, 0);
    get_pkt("R2 R4 dev read");
    send_cpl("R9 dev read cpl", 8'h50, 8'h21, 8'h00, 40'h00403FB2A1, 4, 8'h04, 1'b0);
    wait_rsp("R9 dev read", 32'h403FB2A1, 3'd4);
  endtask

  task automatic t_dev_write_clamp();
    issue(2'd1, 16'h8003, 32'h44332211, 3'd6);
    mk_exp(8'h21, 8'h13, 8'h00, 16'h8003, 32'h44332211, 4);
    get_pkt("R5 R6 dev write clamp");
    send_cpl("R9 dev write cpl", 8'h50, 8'h31, 8'h00, 40'h0, 0, 8'h00, 1'b0);
    wait_rsp("R9 dev write", 32'h0, 3'd0);
  endtask

  task automatic t_bad_cpl();
    issue(2'd0, 16'h0010, 32'h0, 3'd0);
    mk_exp(8'h10, 8'h10, 8'h01, 16'h0010, 32'h0, 0);
    get_pkt("R5 mem read tag 1");
    send_cpl("R10 wrong tag", 8'h50, 8'h01, 8'h02, 40'h0, 0, 8'h00, 1'b1);
    send_cpl("R10 wrong dst", 8'h50, 8'h02, 8'h01, 40'h0, 0, 8'h00, 1'b1);
    send_cpl("R10 wrong src", 8'h50, 8'h21, 8'h01, 40'h0, 0, 8'h00, 1'b1);
    send_cpl("R10 bad check", 8'h50, 8'h01, 8'h01, 40'h6B5A, 2, 8'h03, 1'b1);
    send_cpl("R10 bad code", 8'h40, 8'h01, 8'h01, 40'h0, 0, 8'h00, 1'b1);
    send_cpl("R10 five bytes", 8'h50, 8'h01, 8'h01, 40'h0102030405, 5, 8'h05, 1'b1);
    @(negedge clk);
    chk("R10 dropped, no reply", 32'(rsp_valid), 32'd0);
    chk("R10 still pending", 32'(req_ready), 32'd0);
    send_cpl("R9 good after bad", 8'h50, 8'h01, 8'h01, 40'h6B5A, 2, 8'h02, 1'b0);
    wait_rsp("R9 two bytes", 32'h00006B5A, 3'd2);
  endtask

  task automatic t_idle_cpl();
    send_cpl("R11 idle completion", 8'h50, 8'h01, 8'h02, 40'h0, 0, 8'h00, 1'b1);
    @(negedge clk);
    chk("R11 no reply", 32'(rsp_valid), 32'd0);
    chk("R11 still idle", 32'(req_ready), 32'd1);
  endtask

  task automatic t_stall_again();
    issue(2'd0, 16'h8002, 32'h0, 3'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R8 credits used up", 32'(tx_valid), 32'd0);
      @(negedge clk);
    end
    grant();
    mk_exp(8'h20, 8'h12, 8'h01, 16'h8002, 32'h0, 0);
    get_pkt("R5 dev2 second tag");
    send_cpl("R9 dev2 cpl", 8'h50, 8'h21, 8'h01, 40'h0, 0, 8'h00, 1'b0);
    wait_rsp("R9 dev2 empty", 32'h0, 3'd0);
  endtask

  task automatic t_tag_wrap();
    for (int k = 0; k < 3; k++) begin
      logic [7:0]  t;
      logic [15:0] a;
      t = 8'((k + 2) % 4);
      a = 16'(16'h0020 + 16 * k);
      issue(2'd0, a, 32'h0, 3'd0);
      mk_exp(8'h10, 8'h10, t, a, 32'h0, 0);
      get_pkt($sformatf("R5 mem tag wrap %0d", k));
      send_cpl("R9 wrap cpl", 8'h50, 8'h01, t, 40'h77, 1, 8'h01, 1'b0);
      wait_rsp("R9 wrap reply", 32'h77, 3'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_credit_and_mem_write();
    t_illegal_cmd();
    t_dev_read();
    t_dev_write_clamp();
    t_bad_cpl();
    t_idle_cpl();
    t_stall_again();
    t_tag_wrap();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule